// File: doc/BRIEF.md
# Interrupt Acknowledge Arbiter

This block settles which module answers an interrupt acknowledge cycle when several modules request service at the same priority level. Every module slot presents a pending request level (1 to 7, with 0 meaning idle) and a 4-bit arbitration number. When the CPU acknowledges a level, only the slots pending at exactly that level compete. Among them, the slot with the largest nonzero arbitration number wins, and the block returns its index.

Slot 0 belongs to the system module. Its arbitration number is held in a local register that reset sets to 0xF, the highest precedence, and software can rewrite it. External interrupt requests have no slot of their own. They are treated as requests from slot 0 and use slot 0's arbitration number.

An acknowledge that finds no eligible responder is reported as spurious. An acknowledge where two competitors share the top nonzero number is also reported as spurious, and a conflict flag is raised with it. The result is registered one clock after the acknowledge strobe is first seen high. It stays frozen until the strobe falls, and the outputs clear on the clock after that.

Top module: `irq_ack_arbiter`

## Requirements
- R1: During and after reset, win_vld, spurious and conflict are 0 and win_idx is 0. The slot 0 arbitration number resets to 0xF.
- R2: A slot competes only when its request level is nonzero and equal to ack_lvl. Slots pending at any other level do not change the outcome.
- R3: Among the competitors, the one with the highest arbitration number wins. win_idx gives its slot number (0 to N-1) and win_vld is 1.
- R4: A competitor whose arbitration number is 0 never wins. If no competitor has a nonzero number, spurious is 1, win_vld is 0, conflict is 0 and win_idx is 0.
- R5: If two or more competitors share the highest nonzero number, conflict and spurious are both 1, win_vld is 0 and win_idx is 0. A tie below the highest number has no effect.
- R6: A nonzero ext_lvl equal to ack_lvl makes slot 0 compete using the slot 0 arbitration number, even when slot 0's own request level does not match.
- R7: When sys_arb_we is 1 at a clock edge, the slot 0 arbitration number takes sys_arb_wdata. Writing 0 leaves slot 0 unable to win.
- R8: The result appears on the first clock edge at which ack_stb is 1 and is visible after that edge. While ack_stb stays 1, the outputs hold even if the request inputs change.
- R9: At the first clock edge with ack_stb at 0, win_vld, spurious, conflict and win_idx all return to 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_stb | input | 1 | Interrupt acknowledge strobe |
| ack_lvl | input | 3 | Level being acknowledged |
| req_lvl | input | N*3 | Pending request level per slot, slot i at bits [3i+2:3i] |
| arb_num | input | (N-1)*4 | Arbitration numbers of slots 1..N-1, slot i at bits [4(i-1)+3:4(i-1)] |
| ext_lvl | input | 3 | External interrupt request level, mapped to slot 0 |
| sys_arb_we | input | 1 | Write enable for the slot 0 arbitration number |
| sys_arb_wdata | input | 4 | New slot 0 arbitration number |
| win_idx | output | $clog2(N) | Index of the winning slot |
| win_vld | output | 1 | A unique winner was found |
| spurious | output | 1 | No unique eligible responder |
| conflict | output | 1 | Tie at the top nonzero arbitration number |

## Verification
The arbitration path is driven with four kinds of pattern: distinct numbers at one level, to confirm the maximum is taken; a higher number placed at a different level, to show that level filtering applies before the comparison; competitors whose number is zero, or no competitors at all, to separate an empty field from a real winner; and equal numbers, first at the top and then below it, to show that only a tie at the top is a conflict. External requests are checked against the reset value of the slot 0 number and then against rewritten values, including zero and a value equal to another slot's number. After each acknowledge, the inputs are disturbed while the strobe is held to confirm the result does not move, and the strobe is then dropped to confirm the outputs clear.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int LVL_W = 3;
    localparam int ARB_W = 4;
    localparam logic [ARB_W-1:0] SYS_ARB_RST = 4'hF;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [ARB_W-1:0] arb_t;
endpackage

// File: rtl/irq_arb_match.sv
module irq_arb_match
    import irq_arb_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N*LVL_W-1:0] req_lvl,
    input  logic [N*ARB_W-1:0] arb_all,
    input  lvl_t               ext_lvl,
    input  lvl_t               ack_lvl,
    output logic [N-1:0]       elig
);
    for (genvar g = 0; g < N; g++) begin : g_slot
        lvl_t lvl_g;
        arb_t arb_g;
        logic hit_g;
        assign lvl_g = req_lvl[g*LVL_W +: LVL_W];
        assign arb_g = arb_all[g*ARB_W +: ARB_W];
        if (g == 0) begin : g_sys
            assign hit_g = ((lvl_g != '0) && (lvl_g == ack_lvl)) ||
                           ((ext_lvl != '0) && (ext_lvl == ack_lvl));
        end else begin : g_mod
            assign hit_g = (lvl_g != '0) && (lvl_g == ack_lvl);
        end
        assign elig[g] = hit_g && (arb_g != '0);
    end
endmodule

// File: rtl/irq_arb_select.sv
module irq_arb_select
    import irq_arb_pkg::*;
#(
    parameter int N = 8,
    localparam int IDX_W = $clog2(N),
    localparam int CNT_W = $clog2(N + 1)
) (
    input  logic [N-1:0]       elig,
    input  logic [N*ARB_W-1:0] arb_all,
    output logic               any,
    output logic               multi,
    output logic [IDX_W-1:0]   idx
);
    arb_t             best;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        best = '0;
        idx  = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (arb_all[i*ARB_W +: ARB_W] > best)) begin
                best = arb_all[i*ARB_W +: ARB_W];
                idx  = IDX_W'(i);
            end
        end
        cnt = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (arb_all[i*ARB_W +: ARB_W] == best)) begin
                cnt = cnt + CNT_W'(1);
            end
        end
        any   = (best != '0);
        multi = any && (cnt > CNT_W'(1));
    end
endmodule

// File: rtl/irq_ack_arbiter.sv
module irq_ack_arbiter
    import irq_arb_pkg::*;
#(
    parameter int N = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ack_stb,
    input  logic [LVL_W-1:0]       ack_lvl,
    input  logic [N*LVL_W-1:0]     req_lvl,
    input  logic [(N-1)*ARB_W-1:0] arb_num,
    input  logic [LVL_W-1:0]       ext_lvl,
    input  logic                   sys_arb_we,
    input  logic [ARB_W-1:0]       sys_arb_wdata,
    output logic [IDX_W-1:0]       win_idx,
    output logic                   win_vld,
    output logic                   spurious,
    output logic                   conflict
);
    typedef struct packed {
        logic             busy;
        logic             vld;
        logic             spur;
        logic             conf;
        logic [IDX_W-1:0] idx;
        arb_t             sys_arb;
    } state_t;

    state_t st_d, st_q;

    logic [N*ARB_W-1:0] arb_all;
    logic [N-1:0]       elig;
    logic               sel_any, sel_multi;
    logic [IDX_W-1:0]   sel_idx;

    assign arb_all = {arb_num, st_q.sys_arb};

    irq_arb_match #(.N(N)) u_match (
        .req_lvl (req_lvl),
        .arb_all (arb_all),
        .ext_lvl (ext_lvl),
        .ack_lvl (ack_lvl),
        .elig    (elig)
    );

    irq_arb_select #(.N(N)) u_select (
        .elig    (elig),
        .arb_all (arb_all),
        .any     (sel_any),
        .multi   (sel_multi),
        .idx     (sel_idx)
    );

    always_comb begin
        st_d = st_q;
        if (sys_arb_we) begin
            st_d.sys_arb = sys_arb_wdata;
        end
        if (!ack_stb) begin
            st_d.busy = 1'b0;
            st_d.vld  = 1'b0;
            st_d.spur = 1'b0;
            st_d.conf = 1'b0;
            st_d.idx  = '0;
        end else if (!st_q.busy) begin
            st_d.busy = 1'b1;
            st_d.vld  = sel_any && !sel_multi;
            st_d.spur = !sel_any || sel_multi;
            st_d.conf = sel_multi;
            st_d.idx  = (sel_any && !sel_multi) ? sel_idx : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.sys_arb <= SYS_ARB_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_idx  = st_q.idx;
    assign win_vld  = st_q.vld;
    assign spurious = st_q.spur;
    assign conflict = st_q.conf;

    assert_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && !st_q.busy) |=> (win_vld || spurious));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && st_q.busy) |=>
            ($stable(win_idx) && $stable(win_vld) && $stable(spurious) && $stable(conflict)));

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_stb |=> !(win_vld || spurious || conflict) && (win_idx == '0));

    assert_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({win_vld, spurious}) && (!conflict || spurious));

    assert_no_responder_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && !st_q.busy && !sel_any) |=> (spurious && !conflict && !win_vld));
endmodule

// File: tb/tb_irq_ack_arbiter.sv
module tb_irq_ack_arbiter;
    localparam int N = 8;

    typedef struct {
        logic vld;
        logic spur;
        logic conf;
        int   idx;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ack_stb = 1'b0;
    logic [2:0] ack_lvl = '0;
    logic [N*3-1:0] req_lvl;
    logic [(N-1)*4-1:0] arb_num;
    logic [2:0] ext_lvl = '0;
    logic sys_arb_we = 1'b0;
    logic [3:0] sys_arb_wdata = '0;
    logic [2:0] win_idx;
    logic win_vld, spurious, conflict;

    logic [2:0] lvl_m [N];
    logic [3:0] arb_m [N];
    logic [3:0] sys_m = 4'hF;

    int n_chk = 0;
    int n_fail = 0;
    exp_t exp_q[$];
    exp_t last_exp;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) req_lvl[i*3 +: 3] = lvl_m[i];
        for (int i = 1; i < N; i++) arb_num[(i-1)*4 +: 4] = arb_m[i];
    end

    irq_ack_arbiter #(.N(N)) dut (
        .clk(clk), .rst_n(rst_n), .ack_stb(ack_stb), .ack_lvl(ack_lvl),
        .req_lvl(req_lvl), .arb_num(arb_num), .ext_lvl(ext_lvl),
        .sys_arb_we(sys_arb_we), .sys_arb_wdata(sys_arb_wdata),
        .win_idx(win_idx), .win_vld(win_vld), .spurious(spurious), .conflict(conflict)
    );

    task automatic chk(input string req, input int got, input int want);
        n_chk++;
        if (got != want) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, want);
        end
    endtask

    task automatic cmp(input string req, input exp_t e);
        chk({req, " vld"}, int'(win_vld), int'(e.vld));
        chk({req, " spur"}, int'(spurious), int'(e.spur));
        chk({req, " conf"}, int'(conflict), int'(e.conf));
        chk({req, " idx"}, int'(win_idx), e.idx);
    endtask

    function automatic exp_t model(input logic [2:0] ack);
        exp_t e;
        int best = 0;
        int cnt = 0;
        int bidx = 0;
        for (int i = 0; i < N; i++) begin
            bit part = (lvl_m[i] != 0 && lvl_m[i] == ack) ||
                       (i == 0 && ext_lvl != 0 && ext_lvl == ack);
            int a = (i == 0) ? int'(sys_m) : int'(arb_m[i]);
            if (part && a != 0 && a > best) begin best = a; bidx = i; end
        end
        for (int i = 0; i < N; i++) begin
            bit part = (lvl_m[i] != 0 && lvl_m[i] == ack) ||
                       (i == 0 && ext_lvl != 0 && ext_lvl == ack);
            int a = (i == 0) ? int'(sys_m) : int'(arb_m[i]);
            if (part && a != 0 && a == best) cnt++;
        end
        e.vld  = (best != 0) && (cnt == 1);
        e.spur = (best == 0) || (cnt > 1);
        e.conf = (best != 0) && (cnt > 1);
        e.idx  = e.vld ? bidx : 0;
        return e;
    endfunction

    // monitor: pops one expected result after the edge that latches it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                last_exp = exp_q.pop_front();
                cmp("R3/R8 result", last_exp);
            end
        end
    end

    task automatic clear_reqs();
        for (int i = 0; i < N; i++) begin lvl_m[i] = '0; arb_m[i] = '0; end
        ext_lvl = '0;
    endtask

    task automatic wr_sys(input logic [3:0] v);
        @(negedge clk);
        sys_arb_we = 1'b1; sys_arb_wdata = v;
        @(negedge clk);
        sys_arb_we = 1'b0;
        sys_m = v;
    endtask

    // driver: raise strobe, push expectation, disturb inputs, check hold and clear
    task automatic run_ack(input logic [2:0] lvl);
        logic [2:0] sv_lvl [N];
        exp_t e;
        @(negedge clk);
        ack_lvl = lvl;
        ack_stb = 1'b1;
        e = model(lvl);
        exp_q.push_back(e);
        @(negedge clk);
        for (int i = 0; i < N; i++) begin sv_lvl[i] = lvl_m[i]; lvl_m[i] = lvl; end
        @(negedge clk);
        cmp("R8 hold", e);
        for (int i = 0; i < N; i++) lvl_m[i] = sv_lvl[i];
        ack_stb = 1'b0;
        @(negedge clk);
        chk("R9 clear vld", int'(win_vld), 0);
        chk("R9 clear spur", int'(spurious), 0);
        chk("R9 clear conf", int'(conflict), 0);
        chk("R9 clear idx", int'(win_idx), 0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        clear_reqs();
        repeat (3) @(negedge clk);
        chk("R1 reset vld", int'(win_vld), 0);
        chk("R1 reset spur", int'(spurious), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset idx", int'(win_idx), 0);
        chk("R1 after reset conf", int'(conflict), 0);

        // R3: distinct numbers at one level
        lvl_m[2] = 3'd3; arb_m[2] = 4'd4;
        lvl_m[5] = 3'd3; arb_m[5] = 4'd9;
        run_ack(3'd3);
        chk("R3 winner slot 5", last_exp.idx, 5);

        // R2: higher number at another level is ignored
        lvl_m[6] = 3'd4; arb_m[6] = 4'd15;
        run_ack(3'd3);
        chk("R2 other level ignored", last_exp.idx, 5);
        run_ack(3'd4);

        // R4: zero arbitration number, and empty level
        clear_reqs();
        lvl_m[3] = 3'd2; arb_m[3] = 4'd0;
        run_ack(3'd2);
        chk("R4 zero arb spurious", int'(last_exp.spur), 1);
        run_ack(3'd7);

        // R5: tie at top, then tie below top
        clear_reqs();
        lvl_m[1] = 3'd5; arb_m[1] = 4'd7;
        lvl_m[4] = 3'd5; arb_m[4] = 4'd7;
        run_ack(3'd5);
        chk("R5 top tie conflict", int'(last_exp.conf), 1);
        lvl_m[2] = 3'd5; arb_m[2] = 4'd10;
        run_ack(3'd5);
        chk("R5 lower tie ignored", last_exp.idx, 2);

        // R6: external request via slot 0 with reset number 0xF
        clear_reqs();
        ext_lvl = 3'd6;
        lvl_m[7] = 3'd6; arb_m[7] = 4'd14;
        run_ack(3'd6);
        chk("R6 R1 ext wins slot 0", last_exp.idx, 0);

        // R7: rewrite slot 0 number
        wr_sys(4'd3);
        run_ack(3'd6);
        chk("R7 lower sys loses", last_exp.idx, 7);
        wr_sys(4'd14);
        run_ack(3'd6);
        chk("R7 equal sys conflict", int'(last_exp.conf), 1);
        wr_sys(4'd0);
        lvl_m[7] = 3'd0;
        run_ack(3'd6);
        chk("R7 zero sys spurious", int'(last_exp.spur), 1);

        // R6: own slot 0 level also works
        wr_sys(4'd5);
        ext_lvl = 3'd0;
        lvl_m[0] = 3'd1; lvl_m[6] = 3'd1; arb_m[6] = 4'd2;
        run_ack(3'd1);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule